// File: doc/BRIEF.md
# Instruction Fetch and Call Unit

This unit walks a program held in a word-addressed memory of 64K 16-bit words. Its program counter is the memory address bus, so the word at the current address is available for decoding in the same cycle. The unit sorts each fetched word into one of two kinds. A word whose upper byte is all ones is a microcoded operation, and its lower byte goes to the microcode sequencer. Every other word is the address of a subroutine, and the unit jumps to it.

A call takes one cycle. In that cycle the return address, which is the current address plus one, is captured in a save register while the program counter loads the target. In the next cycle, which is the first fetch at the target, the save register is written onto a 256-entry return stack. No cycle is spent on the push or on a separate increment.

While an operation is executing, the sequencer controls the unit through four command inputs: finish and fetch the next word, return from a subroutine, branch on a condition, or overwrite the return stack pointer. A branch target is the memory word that follows the branch opcode, so the program counter already addresses it when the sequencer decides.

Top module: `fetch_call_unit`

## Requirements
- R1: While reset is held, and directly after it, mem_addr is 0x0000, rsp is 0 and op_valid is 0.
- R2: In a fetch cycle, a word with bits 15:8 equal to 0xFF moves the unit to execute at the next edge. op_valid goes to 1, op_code takes bits 7:0 of the word, and mem_addr advances by one.
- R3: In a fetch cycle, a word whose bits 15:8 are not 0xFF is a call. At the next edge mem_addr equals that word and op_valid stays 0.
- R4: One edge after a call, the return address (call address plus one) is written at rsp+1 and rsp increments by one. A later return comes back to that address.
- R5: seq_ret in execute loads mem_addr from the stack entry at rsp, decrements rsp and ends the operation (op_valid 0). seq_ret has priority over all other commands.
- R6: seq_branch with seq_taken=1 in execute, and without seq_ret, loads mem_addr with the word now on mem_rdata (the word after the opcode) and ends the operation.
- R7: seq_branch with seq_taken=0 in execute advances mem_addr past the inline word by one and ends the operation.
- R8: seq_next in execute, with neither seq_ret nor seq_branch, ends the operation and leaves mem_addr unchanged.
- R9: rsp_we in execute, without seq_ret, sets rsp to rsp_wdata at the next edge and does not end the operation. When seq_ret is also asserted, the pointer write is ignored.
- R10: The 8-bit stack pointer wraps. A push at rsp 255 writes entry 0 and leaves rsp at 0. A pop at rsp 0 reads entry 0 and leaves rsp at 255.
- R11: All sequencer commands, rsp_we included, are ignored in fetch cycles.
- R12: Calls nested back to back, where a call target is itself a call, push both return addresses. The returns then come back in last-in, first-out order.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| mem_addr | output | 16 | Program memory word address (the program counter) |
| mem_rdata | input | 16 | Word read from mem_addr, valid in the same cycle |
| op_valid | output | 1 | High while a microcoded operation executes |
| op_code | output | 8 | Opcode of the current operation |
| seq_next | input | 1 | Sequencer: operation done, fetch next word |
| seq_branch | input | 1 | Sequencer: branch using the inline target word |
| seq_taken | input | 1 | Branch condition for seq_branch |
| seq_ret | input | 1 | Sequencer: return from subroutine |
| rsp_we | input | 1 | Write the return stack pointer |
| rsp_wdata | input | 8 | New return stack pointer value |
| rsp | output | 8 | Current return stack pointer |

## Verification
The bench drives the corner cases where the push is late by one cycle. These are a call whose target is itself a call, and a return issued right after a call lands on an opcode. If the push is lost or writes the wrong slot, the return goes to a stale address. The bench also steps the pointer across the 255/0 boundary in both directions. A pointer that saturates, or that reads the slot above the top, returns to the wrong address. Finally it asserts commands during fetch cycles and combines a pointer write with a return. A design without proper gating would pop, or it would leave the pointer at the written value rather than the decremented one.

// File: rtl/fcu_pkg.sv
package fcu_pkg;
  localparam int WORD_W = 16;
  localparam int OPC_W  = 8;
  localparam int TAG_W  = WORD_W - OPC_W;

  typedef logic [WORD_W-1:0] word_t;
  typedef logic [OPC_W-1:0]  opc_t;

  typedef enum logic {
    ST_FETCH = 1'b0,
    ST_EXEC  = 1'b1
  } fcu_state_e;

  // True when the upper byte marks a microcoded operation
  function automatic logic is_microop(input word_t w);
    return &w[WORD_W-1:OPC_W];
  endfunction

  // Sequential successor of a word address (wraps at the top)
  function automatic word_t addr_step(input word_t a);
    return a + word_t'(1);
  endfunction

  // Low byte handed to the sequencer
  function automatic opc_t opcode_of(input word_t w);
    return w[OPC_W-1:0];
  endfunction
endpackage

// File: rtl/fcu_decode.sv
module fcu_decode
  import fcu_pkg::*;
(
  input  word_t word_i,
  output logic  is_op_o,
  output opc_t  opcode_o,
  output word_t target_o
);
  always_comb begin
    is_op_o  = is_microop(word_i);
    opcode_o = opcode_of(word_i);
    target_o = word_i;
  end
endmodule

// File: rtl/fcu_retstack.sv
module fcu_retstack
  import fcu_pkg::*;
#(
  parameter int AW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push_i,
  input  word_t         push_data_i,
  input  logic          pop_i,
  input  logic          ptr_we_i,
  input  logic [AW-1:0] ptr_wdata_i,
  output word_t         top_o,
  output logic [AW-1:0] ptr_o
);
  localparam int DEPTH = 1 << AW;
  localparam logic [AW-1:0] ONE = AW'(1);

  word_t         ram [DEPTH];
  logic [AW-1:0] ptr_q;
  logic [AW-1:0] ptr_up;
  logic [AW-1:0] ptr_dn;

  assign ptr_up = ptr_q + ONE;
  assign ptr_dn = ptr_q - ONE;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ptr_q <= '0;
    end else if (push_i) begin
      ptr_q <= ptr_up;
    end else if (pop_i) begin
      ptr_q <= ptr_dn;
    end else if (ptr_we_i) begin
      ptr_q <= ptr_wdata_i;
    end
  end

  always_ff @(posedge clk) begin
    if (push_i) begin
      ram[ptr_up] <= push_data_i;
    end
  end

  assign top_o = ram[ptr_q];
  assign ptr_o = ptr_q;
endmodule

// File: rtl/fcu_pcpath.sv
module fcu_pcpath
  import fcu_pkg::*;
#(
  parameter word_t RESET_PC = '0
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  call_i,
  input  word_t call_tgt_i,
  input  logic  step_i,
  input  logic  ret_i,
  input  word_t ret_addr_i,
  input  logic  jump_i,
  input  word_t jump_tgt_i,
  output word_t pc_o,
  output word_t save_o,
  output logic  push_pend_o
);
  word_t pc_q;
  word_t save_q;
  logic  pend_q;
  word_t pc_d;

  always_comb begin
    pc_d = pc_q;
    if (call_i) begin
      pc_d = call_tgt_i;
    end else if (ret_i) begin
      pc_d = ret_addr_i;
    end else if (jump_i) begin
      pc_d = jump_tgt_i;
    end else if (step_i) begin
      pc_d = addr_step(pc_q);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pc_q   <= RESET_PC;
      save_q <= '0;
      pend_q <= 1'b0;
    end else begin
      pc_q   <= pc_d;
      pend_q <= call_i;
      if (call_i) begin
        save_q <= addr_step(pc_q);
      end
    end
  end

  assign pc_o        = pc_q;
  assign save_o      = save_q;
  assign push_pend_o = pend_q;
endmodule

// File: rtl/fetch_call_unit.sv
module fetch_call_unit
  import fcu_pkg::*;
#(
  parameter int    RS_AW    = 8,
  parameter word_t RESET_PC = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  output logic [15:0]      mem_addr,
  input  logic [15:0]      mem_rdata,
  output logic             op_valid,
  output logic [7:0]       op_code,
  input  logic             seq_next,
  input  logic             seq_branch,
  input  logic             seq_taken,
  input  logic             seq_ret,
  input  logic             rsp_we,
  input  logic [RS_AW-1:0] rsp_wdata,
  output logic [RS_AW-1:0] rsp
);
  fcu_state_e state_q;
  fcu_state_e state_d;
  opc_t       opc_q;

  logic  in_fetch;
  logic  dec_is_op;
  opc_t  dec_opc;
  word_t dec_tgt;
  word_t pc;
  word_t save_val;
  word_t stack_top;
  logic  push_pend;

  // Named internal events
  logic call_fire;
  logic op_fire;
  logic push_fire;
  logic pop_fire;
  logic br_fire;
  logic br_take;
  logic br_skip;
  logic next_fire;
  logic ptr_wr_fire;

  fcu_decode u_dec (
    .word_i   (mem_rdata),
    .is_op_o  (dec_is_op),
    .opcode_o (dec_opc),
    .target_o (dec_tgt)
  );

  assign in_fetch    = (state_q == ST_FETCH);
  assign call_fire   = in_fetch && !dec_is_op;
  assign op_fire     = in_fetch && dec_is_op;
  assign push_fire   = push_pend;
  assign pop_fire    = !in_fetch && seq_ret;
  assign br_fire     = !in_fetch && !seq_ret && seq_branch;
  assign br_take     = br_fire && seq_taken;
  assign br_skip     = br_fire && !seq_taken;
  assign next_fire   = !in_fetch && !seq_ret && !seq_branch && seq_next;
  assign ptr_wr_fire = !in_fetch && !seq_ret && rsp_we;

  fcu_pcpath #(
    .RESET_PC (RESET_PC)
  ) u_pc (
    .clk         (clk),
    .rst_n       (rst_n),
    .call_i      (call_fire),
    .call_tgt_i  (dec_tgt),
    .step_i      (op_fire || br_skip),
    .ret_i       (pop_fire),
    .ret_addr_i  (stack_top),
    .jump_i      (br_take),
    .jump_tgt_i  (mem_rdata),
    .pc_o        (pc),
    .save_o      (save_val),
    .push_pend_o (push_pend)
  );

  fcu_retstack #(
    .AW (RS_AW)
  ) u_rs (
    .clk         (clk),
    .rst_n       (rst_n),
    .push_i      (push_fire),
    .push_data_i (save_val),
    .pop_i       (pop_fire),
    .ptr_we_i    (ptr_wr_fire),
    .ptr_wdata_i (rsp_wdata),
    .top_o       (stack_top),
    .ptr_o       (rsp)
  );

  always_comb begin
    state_d = state_q;
    if (op_fire) begin
      state_d = ST_EXEC;
    end else if (pop_fire || br_fire || next_fire) begin
      state_d = ST_FETCH;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_FETCH;
      opc_q   <= '0;
    end else begin
      state_q <= state_d;
      if (op_fire) begin
        opc_q <= dec_opc;
      end
    end
  end

  assign mem_addr = pc;
  assign op_valid = (state_q == ST_EXEC);
  assign op_code  = opc_q;
endmodule

// File: rtl/fcu_checker.sv
module fcu_checker #(
  parameter int RS_AW = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic [15:0]      mem_addr,
  input logic [15:0]      mem_rdata,
  input logic             op_valid,
  input logic [7:0]       op_code,
  input logic             seq_ret,
  input logic             rsp_we,
  input logic [RS_AW-1:0] rsp_wdata,
  input logic [RS_AW-1:0] rsp,
  input logic             call_fire,
  input logic             op_fire,
  input logic             push_fire,
  input logic             pop_fire,
  input logic             br_fire,
  input logic             next_fire
);
  // R2
  opcode_handoff_chk: assert property (@(posedge clk) disable iff (!rst_n)
    op_fire |=> (op_valid && op_code == $past(mem_rdata[7:0])
                 && mem_addr == $past(mem_addr) + 16'd1));

  // R3
  call_target_chk: assert property (@(posedge clk) disable iff (!rst_n)
    call_fire |=> (!op_valid && mem_addr == $past(mem_rdata)));

  // R4
  push_follows_call_chk: assert property (@(posedge clk) disable iff (!rst_n)
    call_fire |=> push_fire);

  // R4
  push_bumps_ptr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    push_fire |=> rsp == $past(rsp) + 1'b1);

  // R5
  pop_drops_ptr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pop_fire |=> (!op_valid && rsp == $past(rsp) - 1'b1));

  // R9
  ptr_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && rsp_we && !seq_ret) |=> (rsp == $past(rsp_wdata) && op_valid));

  // R11
  fetch_ignores_seq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !op_valid |=> (mem_addr == $past(mem_rdata) || mem_addr == $past(mem_addr) + 16'd1));

  // R8
  next_holds_pc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    next_fire |=> (!op_valid && $stable(mem_addr)));

  // R5
  exec_cmd_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({pop_fire, br_fire, next_fire}));
endmodule

bind fetch_call_unit fcu_checker #(.RS_AW(RS_AW)) u_chk (.*);

// File: tb/fetch_call_unit_tb.sv
module fetch_call_unit_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] mem_addr;
  logic [15:0] mem_rdata;
  logic        op_valid;
  logic [7:0]  op_code;
  logic        seq_next = 1'b0;
  logic        seq_branch = 1'b0;
  logic        seq_taken = 1'b0;
  logic        seq_ret = 1'b0;
  logic        rsp_we = 1'b0;
  logic [7:0]  rsp_wdata = '0;
  logic [7:0]  rsp;

  logic [15:0] mem [1024];
  int n_checks = 0;
  int n_fails  = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  assign mem_rdata = mem[mem_addr[9:0]];

  fetch_call_unit u_dut (
    .clk(clk), .rst_n(rst_n), .mem_addr(mem_addr), .mem_rdata(mem_rdata),
    .op_valid(op_valid), .op_code(op_code), .seq_next(seq_next),
    .seq_branch(seq_branch), .seq_taken(seq_taken), .seq_ret(seq_ret),
    .rsp_we(rsp_we), .rsp_wdata(rsp_wdata), .rsp(rsp)
  );

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic clear_cmds();
    seq_next = 0; seq_branch = 0; seq_taken = 0; seq_ret = 0; rsp_we = 0; rsp_wdata = '0;
  endtask

  task automatic start();
    clear_cmds();
    rst_n = 0;
    repeat (2) @(negedge clk);
    rst_n = 1;
  endtask

  task automatic wipe();
    for (int i = 0; i < 1024; i++) mem[i] = 16'h0000;
  endtask

  task automatic t_reset();
    wipe();
    mem[0] = 16'hFF01;
    clear_cmds();
    rst_n = 0;
    repeat (2) @(negedge clk);
    check("R1 mem_addr", mem_addr, 16'h0000);
    check("R1 rsp", {8'h0, rsp}, 16'h0000);
    check("R1 op_valid", {15'h0, op_valid}, 16'h0000);
    rst_n = 1;
  endtask

  task automatic t_opcode_next();
    wipe();
    mem[0] = 16'hFF3C;
    start();
    step();
    check("R2 op_valid", {15'h0, op_valid}, 16'h0001);
    check("R2 op_code", {8'h0, op_code}, 16'h003C);
    check("R2 mem_addr", mem_addr, 16'h0001);
    seq_next = 1;
    step();
    clear_cmds();
    check("R8 op_valid", {15'h0, op_valid}, 16'h0000);
    check("R8 mem_addr", mem_addr, 16'h0001);
  endtask

  task automatic t_call_ret();
    wipe();
    mem[0] = 16'h0040;
    mem[16'h40] = 16'hFF01;
    start();
    step();
    check("R3 mem_addr", mem_addr, 16'h0040);
    check("R3 op_valid", {15'h0, op_valid}, 16'h0000);
    step();
    check("R4 rsp", {8'h0, rsp}, 16'h0001);
    check("R4 op_code", {8'h0, op_code}, 16'h0001);
    seq_ret = 1;
    step();
    clear_cmds();
    check("R5 mem_addr", mem_addr, 16'h0001);
    check("R5 rsp", {8'h0, rsp}, 16'h0000);
    check("R5 op_valid", {15'h0, op_valid}, 16'h0000);
  endtask

  task automatic t_branch(input bit taken);
    wipe();
    mem[0] = 16'hFF10;
    mem[1] = 16'h0123;
    start();
    step();
    seq_branch = 1;
    seq_taken = taken;
    step();
    clear_cmds();
    if (taken) check("R6 mem_addr", mem_addr, 16'h0123);
    else       check("R7 mem_addr", mem_addr, 16'h0002);
    check(taken ? "R6 op_valid" : "R7 op_valid", {15'h0, op_valid}, 16'h0000);
  endtask

  task automatic t_fetch_ignore();
    wipe();
    mem[0] = 16'h0050;
    mem[16'h50] = 16'hFF02;
    start();
    seq_ret = 1; seq_next = 1; seq_branch = 1; seq_taken = 1;
    rsp_we = 1; rsp_wdata = 8'h77;
    step();
    clear_cmds();
    check("R11 mem_addr", mem_addr, 16'h0050);
    check("R11 rsp", {8'h0, rsp}, 16'h0000);
    step();
    check("R11 rsp after push", {8'h0, rsp}, 16'h0001);
  endtask

  task automatic t_ptr_write();
    wipe();
    mem[0] = 16'h0040;
    mem[16'h40] = 16'hFF05;
    start();
    step();
    step();
    rsp_we = 1; rsp_wdata = 8'h05;
    step();
    check("R9 rsp written", {8'h0, rsp}, 16'h0005);
    check("R9 still exec", {15'h0, op_valid}, 16'h0001);
    rsp_wdata = 8'h01;
    step();
    rsp_wdata = 8'h44; seq_ret = 1;
    step();
    clear_cmds();
    check("R9 ret wins rsp", {8'h0, rsp}, 16'h0000);
    check("R9 ret addr", mem_addr, 16'h0001);
  endtask

  task automatic t_wrap();
    wipe();
    mem[0] = 16'hFF00;
    mem[1] = 16'h0060;
    mem[16'h60] = 16'hFF09;
    start();
    step();
    rsp_we = 1; rsp_wdata = 8'hFF;
    step();
    clear_cmds();
    check("R10 rsp set", {8'h0, rsp}, 16'h00FF);
    seq_next = 1;
    step();
    clear_cmds();
    step();
    check("R10 call", mem_addr, 16'h0060);
    step();
    check("R10 push wrap", {8'h0, rsp}, 16'h0000);
    seq_ret = 1;
    step();
    clear_cmds();
    check("R10 pop addr", mem_addr, 16'h0002);
    check("R10 pop wrap", {8'h0, rsp}, 16'h00FF);
  endtask

  task automatic t_nested();
    wipe();
    mem[0] = 16'h0040;
    mem[16'h40] = 16'h0080;
    mem[16'h80] = 16'hFF07;
    mem[16'h41] = 16'hFF08;
    start();
    step();
    step();
    check("R12 second call", mem_addr, 16'h0080);
    step();
    check("R12 depth", {8'h0, rsp}, 16'h0002);
    seq_ret = 1;
    step();
    clear_cmds();
    check("R12 inner ret", mem_addr, 16'h0041);
    step();
    check("R12 op at return", {8'h0, op_code}, 16'h0008);
    seq_ret = 1;
    step();
    clear_cmds();
    check("R12 outer ret", mem_addr, 16'h0001);
    check("R12 empty", {8'h0, rsp}, 16'h0000);
  endtask

  task automatic finish_up();
    if (!finished) begin
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_checks++;
    n_fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_up();
  end

  initial begin
    @(negedge clk);
    t_reset();
    t_opcode_next();
    t_call_ret();
    t_branch(1'b1);
    t_branch(1'b0);
    t_fetch_ignore();
    t_ptr_write();
    t_wrap();
    t_nested();
    finish_up();
  end
endmodule